// File: doc/BRIEF.md
# Framed 14-bit PCM serial port

This block sits between a sampled-data voice core and a framed serial bus. The bus carries a bit clock, a frame sync, a serial data input and an open-drain serial data output. Everything runs on a faster system clock. The bus clock and the sync are oversampled through a synchronizer, and their edges are detected inside the block.

On the receive side, a rising sync edge arms a 14-bit shifter. The shifter samples the serial input on each falling bit-clock edge, most significant bit first. After the fourteenth bit it presents the two's-complement word on a parallel port together with a one-cycle strobe.

On the transmit side, the rising sync edge captures the parallel word and puts its sign bit on the line immediately. Each later bit is launched on a rising bit-clock edge. The line is released once the fourteen bits are done. It is also released whenever the codec is powered off. The pin itself is modelled as an enable plus a pull-low request, so the block can only pull the line low or leave it to the pull-up.

Top module: `pcm14_serial_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rx_valid, sdo_oe, sdo_low and rx_sample are all zero.
- R2: Received words are two's complement. Bit 13 is the sign and is the first bit taken. Bits are taken on falling bit-clock edges, starting with the first falling edge after a rising sync edge, and rx_sample bit 13-k holds the bit taken on the (k+1)th such edge.
- R3: rx_valid is high for exactly one system clock for each completed 14-bit word, and rx_sample changes only in that cycle.
- R4: Bit-clock edges after the fourteenth bit of a frame have no effect until the next rising sync edge. There is no second rx_valid, rx_sample is unchanged and the output stays released.
- R5: The rising sync edge drives the sign bit (tx_sample bit 13) onto the line at once. Each further bit follows on the next rising bit-clock edge that comes after a falling one. A data bit of 0 is sent as sdo_oe=1 with sdo_low=1, and a 1 as sdo_oe=1 with sdo_low=0.
- R6: sdo_oe is high for exactly the 14 bit periods of a frame and drops on the fifteenth rising bit-clock edge of the frame.
- R7: sdo_low is never high while sdo_oe is low.
- R8: With codec_on low, sdo_oe drops within one system clock, and a sync edge that arrives while codec_on is low starts no output window.
- R9: The transmitted word is the value of tx_sample at the rising sync edge; later changes to tx_sample do not alter that frame.
- R10: A sync that rises shortly after a rising bit-clock edge, and a sync that rises in the low phase before it, both frame correctly in both directions.
- R11: A rising sync edge in the middle of a frame restarts both directions. A partly received word is discarded without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| codec_on | input | 1 | High while the codec path is powered |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| fsync_in | input | 1 | Frame sync; its rising edge marks the sign bit |
| sdi | input | 1 | Serial data in |
| tx_sample | input | SAMPLE_W | Word to transmit, taken at the sync edge |
| rx_sample | output | SAMPLE_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_sample |
| sdo_oe | output | 1 | Line driver enabled (inside the bit window) |
| sdo_low | output | 1 | Pull line low (data bit 0) |

## Verification
The embedded assertions check these properties on every cycle:
- the single-cycle strobe and the hold of the received word between strobes;
- the bound on the receive bit count;
- that the output window only ever opens from a sync edge;
- that the window closes after the last bit;
- the release whenever power is off.

Only the bench's frames can show the remaining behaviour:
- the bit order and sign handling of both shifters;
- the two sync phases;
- a frame cut short by a new sync;
- the ignored trailing bit edges;
- that the transmitted word is the one captured at the sync edge and not a later value.

// File: rtl/pcm14_pkg.sv
// Shared defaults for the framed 14-bit PCM serial port.
package pcm14_pkg;
    localparam int PCM_SAMPLE_W    = 14;  // bits per voice word
    localparam int PCM_SYNC_STAGES = 2;   // synchronizer depth for bus inputs
endpackage

// File: rtl/pcm_sync_chain.sv
// Multi-bit synchronizer for asynchronous bus inputs.
// Assumes each bit is an independent level that may be resampled; STAGES >= 1.
module pcm_sync_chain #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES < 2) begin : g_single
            // one stage: plain register
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= din;
            end
        end else begin : g_chain
            // shift the inputs through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcm_rx_shifter.sv
// Receive shifter: after a frame start, takes W bits on falling bit-clock
// events, MSB first, then publishes the word with a one-cycle strobe.
// Assumes event inputs are single-cycle pulses already synchronized to clk.
module pcm_rx_shifter #(
    parameter int W     = 14,
    parameter int CNT_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         bit_fall,
    input  logic         sdi_bit,
    output logic [W-1:0] rx_word,
    output logic         rx_strobe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // arm on sync, shift on falling edges, publish after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            armed     <= 1'b0;
            rx_word   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (frame_start) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed && bit_fall) begin
                shreg <= {shreg[W-2:0], sdi_bit};
                if (cnt == LAST_BIT) begin
                    rx_word   <= {shreg[W-2:0], sdi_bit};
                    rx_strobe <= 1'b1;
                    armed     <= 1'b0;
                    cnt       <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    p_strobe_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |-> $stable(rx_word));
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_BIT);
endmodule

// File: rtl/pcm_tx_shifter.sv
// Transmit shifter: a frame start loads the word and drives its MSB at once;
// each later bit goes out on a rising bit-clock event that follows a falling
// one; the window closes after W bits or when disabled.
// Assumes event inputs are single-cycle pulses already synchronized to clk.
module pcm_tx_shifter #(
    parameter int W     = 14,
    parameter int CNT_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         frame_start,
    input  logic         bit_rise,
    input  logic         bit_fall,
    input  logic [W-1:0] tx_word,
    output logic         oe,
    output logic         pull_low
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;
    logic             oe_q, dat_q, fall_seen;

    // load on sync, launch bits on rising edges, release after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            oe_q      <= 1'b0;
            dat_q     <= 1'b1;
            fall_seen <= 1'b0;
        end else if (!enable) begin
            oe_q      <= 1'b0;
            fall_seen <= 1'b0;
            cnt       <= '0;
        end else if (frame_start) begin
            shreg     <= tx_word;
            dat_q     <= tx_word[W-1];
            cnt       <= CNT_W'(1);
            oe_q      <= 1'b1;
            fall_seen <= 1'b0;
        end else if (oe_q) begin
            if (bit_fall) begin
                fall_seen <= 1'b1;
            end else if (bit_rise && fall_seen) begin
                fall_seen <= 1'b0;
                if (cnt == LAST) begin
                    oe_q <= 1'b0;
                end else begin
                    dat_q <= shreg[W-2];
                    shreg <= {shreg[W-2:0], 1'b0};
                    cnt   <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign oe       = oe_q;
    assign pull_low = oe_q & ~dat_q;

    p_release_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !oe_q);
    p_open_only_on_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(frame_start));
    p_close_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && enable && !frame_start && bit_rise && fall_seen && cnt == LAST) |=> !oe_q);
endmodule

// File: rtl/pcm14_serial_port.sv
// Framed 14-bit PCM serial port. Synchronizes the bus clock, sync and data
// into clk, detects edges, and runs independent receive and transmit
// shifters. Assumes clk is at least several times faster than the bit clock.
module pcm14_serial_port
    import pcm14_pkg::*;
#(
    parameter int SAMPLE_W    = PCM_SAMPLE_W,
    parameter int SYNC_STAGES = PCM_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                codec_on,
    input  logic                bclk_in,
    input  logic                fsync_in,
    input  logic                sdi,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid,
    output logic                sdo_oe,
    output logic                sdo_low
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);

    logic [2:0] lvl;              // {sdi, fsync, bclk} after synchronizer
    logic       bclk_q, fsync_q;
    logic       bclk_rise, bclk_fall, fsync_rise;

    pcm_sync_chain #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdi, fsync_in, bclk_in}),
        .dout (lvl)
    );

    // previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            fsync_q <= 1'b0;
        end else begin
            bclk_q  <= lvl[0];
            fsync_q <= lvl[1];
        end
    end

    assign bclk_rise  =  lvl[0] & ~bclk_q;
    assign bclk_fall  = ~lvl[0] &  bclk_q;
    assign fsync_rise =  lvl[1] & ~fsync_q;

    pcm_rx_shifter #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(fsync_rise),
        .bit_fall   (bclk_fall),
        .sdi_bit    (lvl[2]),
        .rx_word    (rx_sample),
        .rx_strobe  (rx_valid)
    );

    pcm_tx_shifter #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (codec_on),
        .frame_start(fsync_rise),
        .bit_rise   (bclk_rise),
        .bit_fall   (bclk_fall),
        .tx_word    (tx_sample),
        .oe         (sdo_oe),
        .pull_low   (sdo_low)
    );
endmodule

// File: tb/sim_pcm14_serial_port.sv
module sim_pcm14_serial_port;
    localparam int H = 10;  // system clocks per bit-clock half period

    logic        clk = 1'b0, rst_n = 1'b0, codec_on = 1'b1;
    logic        bclk = 1'b0, fsync = 1'b0, sdi = 1'b0;
    logic [13:0] tx_sample = '0;
    logic [13:0] rx_sample;
    logic        rx_valid, sdo_oe, sdo_low;

    int checks = 0, failures = 0;
    int rx_cnt = 0, vdouble = 0;
    logic [13:0] rx_last = '0;
    logic prev_valid = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pcm14_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .codec_on(codec_on), .bclk_in(bclk),
        .fsync_in(fsync), .sdi(sdi), .tx_sample(tx_sample),
        .rx_sample(rx_sample), .rx_valid(rx_valid),
        .sdo_oe(sdo_oe), .sdo_low(sdo_low)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rx_cnt++;
                rx_last = rx_sample;
                if (prev_valid) vdouble++;
            end
            prev_valid = rx_valid;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_oe(input int i, input int off_at);
        return (i < 14) && (i < off_at);
    endfunction

    function automatic bit exp_low(input logic [13:0] w, input int i);
        return ~w[13 - i];
    endfunction

    // phase: 0 sync with bit-clock rise, 1 sync lags rise, 2 sync leads rise
    task automatic run_frame(input logic [13:0] rxw, input logic [13:0] txw,
                             input int phase, input int nbits, input int off_at);
        int base;
        string req;
        base = rx_cnt;
        tx_sample = txw;
        if (off_at == 0) codec_on = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (i == 0 && phase == 2) begin fsync = 1'b1; tick(3); end
            bclk = 1'b1;
            sdi  = (i < 14) ? rxw[13 - i] : 1'($urandom % 2);
            if (i == off_at && off_at > 0) codec_on = 1'b0;
            if (i == 1) fsync = 1'b0;
            if (i == 3) tx_sample = 14'($urandom);   // R9: late change ignored
            if (i == 0 && phase == 0) fsync = 1'b1;
            if (i == 0 && phase == 1) begin tick(2); fsync = 1'b1; tick(H - 2); end
            else tick(H);
            if (off_at < 99 && i >= off_at) req = "R8";
            else if (i >= 14) req = "R4";
            else if (i == 0 && phase != 0) req = "R10";
            else req = "R6";
            chk(sdo_oe == exp_oe(i, off_at), req, sdo_oe, exp_oe(i, off_at));
            if (exp_oe(i, off_at))
                chk(sdo_low == exp_low(txw, i), (i == 0) ? "R5" : "R9",
                    sdo_low, exp_low(txw, i));
            chk(!(sdo_low && !sdo_oe), "R7", sdo_low, 0);
            bclk = 1'b0;
            tick(H);
        end
        codec_on = 1'b1;
        tick(4);
        if (nbits >= 14) begin
            chk(rx_cnt == base + 1, "R3", rx_cnt - base, 1);
            chk(rx_last == rxw, (phase != 0) ? "R10" : "R2", rx_last, rxw);
        end else begin
            chk(rx_cnt == base, "R11", rx_cnt - base, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        tick(5);
        // R1 reset state
        chk(rx_valid == 1'b0, "R1", rx_valid, 0);
        chk(sdo_oe == 1'b0, "R1", sdo_oe, 0);
        chk(sdo_low == 1'b0, "R1", sdo_low, 0);
        chk(rx_sample == 14'h0, "R1", rx_sample, 0);
        rst_n = 1'b1;
        tick(H);
        // directed: full scale, sign edges, zero, R2/R5
        run_frame(14'h1FFF, 14'h2000, 0, 20, 99);
        run_frame(14'h2000, 14'h1FFF, 0, 20, 99);
        run_frame(14'h3FFF, 14'h0001, 1, 18, 99);
        run_frame(14'h0001, 14'h3FFF, 2, 18, 99);
        run_frame(14'h0000, 14'h2AAA, 0, 22, 99);
        // R8: power off for a whole frame, then in mid-frame
        run_frame(14'h1555, 14'h0F0F, 0, 18, 0);
        run_frame(14'h0ABC, 14'h0000, 0, 18, 5);
        // R11: short frame, then a restart
        run_frame(14'h3333, 14'h1234, 0, 8, 99);
        run_frame(14'h0C0C, 14'h2468, 1, 18, 99);
        // random frames
        for (int k = 0; k < 24; k++)
            run_frame(14'($urandom), 14'($urandom), int'($urandom % 3),
                      16 + int'($urandom % 7), 99);
        chk(vdouble == 0, "R3", vdouble, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule